// File: doc/BRIEF.md
# Configurable External Interrupt Edge Detector

This block is the front end for one external interrupt line of a small microcontroller. A 4-bit control word, loaded from the CPU's 4-bit accumulator bus by a write strobe and returned to that bus by a read strobe, sets how the pin is treated. The pin is brought into the clock domain through a flop chain. It is then gated by an enable bit and optionally inverted by a polarity bit. A change on the resulting signal, in one selected direction or in both, sets a sticky interrupt request that the CPU clears with a strobe.

The same polarity bit selects the level that a skip-on-level instruction tests, and the block drives that test result as a plain output. When the timer-routing bit is set, each detected edge also produces a one-cycle start pulse for an associated timer's count-start synchronizer. The gated, polarity-adjusted signal is what gets compared. As a result, rewriting the enable or polarity bit can itself look like an edge and raise the request. A second interrupt pin uses a second instance.

Top module: `xint_edge_unit`

## Requirements
- R1: After reset the control word is 0000, and req_o, tmr_start_o and skip_lvl_o are all 0.
- R2: On a cycle with ctrl_wr_i high, the control word takes acc_wr_i. It changes at no other time. While ctrl_rd_i is high, acc_rd_o shows the control word; otherwise acc_rd_o is 0000.
- R3: While bit 3 (pin enable) is 0 and was 0 on the previous cycle, pin activity never sets req_o, and skip_lvl_o is 0.
- R4: With bit 3 = 1, bit 2 = 0 and bit 1 = 0, a falling pin edge sets req_o. The pin change settles before rising clock edge k, and req_o is high after edge k+2. A rising pin edge sets nothing.
- R5: With bit 3 = 1, bit 2 = 1 and bit 1 = 0, a rising pin edge sets req_o with the same latency as in R4. A falling pin edge sets nothing.
- R6: With bit 3 = 1 and bit 1 = 1, both rising and falling pin edges set req_o with the latency of R4.
- R7: Once set, req_o stays high until req_clr_i is high on a rising clock edge. It is low after that edge if no edge was detected in the same cycle.
- R8: If a detected edge and req_clr_i occur in the same cycle, req_o is high after that clock edge.
- R9: When bit 0 = 1, tmr_start_o is high for the cycle in which req_o is set by a detected edge. When bit 0 = 0, tmr_start_o stays 0. tmr_start_o is never high while req_o is low.
- R10: skip_lvl_o is 1 exactly when bit 3 = 1 and the synchronized pin equals bit 2 (1 = high level, 0 = low level). It follows a pin change after two rising clock edges.
- R11: A control write that changes bit 2 or bit 3 so that the gated, polarity-adjusted signal changes counts as an edge in the current mode. req_o is then high after the second rising clock edge, counting the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Asynchronous external interrupt pin |
| acc_wr_i | input | 4 | Accumulator value to load into the control word |
| ctrl_wr_i | input | 1 | Control word load strobe |
| ctrl_rd_i | input | 1 | Control word read-back strobe |
| acc_rd_o | output | 4 | Control word on read-back, else zero |
| req_clr_i | input | 1 | Clear strobe for the interrupt request |
| req_o | output | 1 | Sticky interrupt request |
| skip_lvl_o | output | 1 | Level-test result for the skip instruction |
| tmr_start_o | output | 1 | One-cycle timer count-start trigger |

## Verification
The properties assume that the clear strobe and both control strobes are ordinary single-cycle synchronous pulses. They also assume the pin is the only asynchronous input. They do not assume the pin is slow, since back-to-back edges in both-edge mode are legal. The stimulus changes every input at the falling clock edge. It holds each pin level for at least three cycles, so every edge passes through the synchronizer on its own before the next one arrives. Clears and same-cycle set/clear collisions are placed at exact cycle offsets from the pin change or the control write.

// File: rtl/xint_pkg.sv
package xint_pkg;

    // Control word, most significant field first: bit3 enable, bit2 polarity,
    // bit1 both-edge mode, bit0 timer routing.
    typedef struct packed {
        logic pin_en;
        logic pol_hi;
        logic both_edge;
        logic tmr_sel;
    } xint_ctrl_t;

    localparam int CTRL_W = $bits(xint_ctrl_t);

    // Event produced by the detector for the request stage.
    typedef struct packed {
        logic hit;
        logic tmr;
    } xint_evt_t;

    // Gated, polarity-adjusted pin level: 1 means "active level present".
    function automatic logic active_level(input logic pin, input xint_ctrl_t c);
        return c.pin_en & (pin == c.pol_hi);
    endfunction

    // Edge on the adjusted signal: rise only, or any change.
    function automatic logic edge_hit(input logic cur, input logic prev, input logic both);
        return both ? (cur ^ prev) : (cur & ~prev);
    endfunction

endpackage

// File: rtl/xint_ctrl_reg.sv
module xint_ctrl_reg
    import xint_pkg::*;
#(
    parameter logic [CTRL_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [CTRL_W-1:0] rd_data,
    output xint_ctrl_t        ctrl_o
);

    xint_ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= xint_ctrl_t'(RST_VAL);
        end else if (wr_en) begin
            ctrl_q <= xint_ctrl_t'(wr_data);
        end
    end

    assign rd_data = rd_en ? CTRL_W'(ctrl_q) : '0;
    assign ctrl_o  = ctrl_q;

    // R2
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctrl_q));

endmodule

// File: rtl/xint_sync.sv
module xint_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/xint_edge_det.sv
module xint_edge_det
    import xint_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_s,
    input  xint_ctrl_t ctrl,
    output xint_evt_t  evt_o,
    output logic       level_o
);

    logic lvl_now;
    logic lvl_q;
    logic en_q;

    assign lvl_now = active_level(pin_s, ctrl);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            en_q  <= 1'b0;
        end else begin
            lvl_q <= lvl_now;
            en_q  <= ctrl.pin_en;
        end
    end

    always_comb begin
        evt_o.hit = edge_hit(lvl_now, lvl_q, ctrl.both_edge);
        evt_o.tmr = evt_o.hit & ctrl.tmr_sel;
    end

    assign level_o = lvl_now;

    // R3
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.pin_en && !en_q) |-> !evt_o.hit);

    // R4
    one_side_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.both_edge && evt_o.hit) |-> level_o);

endmodule

// File: rtl/xint_req_flag.sv
module xint_req_flag
    import xint_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  xint_evt_t evt,
    input  logic      clr,
    output logic      req_o,
    output logic      tmr_o
);

    logic req_q;
    logic tmr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            tmr_q <= 1'b0;
        end else begin
            if (evt.hit)  req_q <= 1'b1;
            else if (clr) req_q <= 1'b0;
            tmr_q <= evt.tmr;
        end
    end

    assign req_o = req_q;
    assign tmr_o = tmr_q;

    // R7
    req_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (req_q && !clr) |=> req_q);

    // R7
    req_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !evt.hit) |=> !req_q);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        evt.hit |=> req_q);

endmodule

// File: rtl/xint_edge_unit.sv
module xint_edge_unit
    import xint_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [CTRL_W-1:0] CTRL_RST    = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_i,
    input  logic [CTRL_W-1:0] acc_wr_i,
    input  logic              ctrl_wr_i,
    input  logic              ctrl_rd_i,
    output logic [CTRL_W-1:0] acc_rd_o,
    input  logic              req_clr_i,
    output logic              req_o,
    output logic              skip_lvl_o,
    output logic              tmr_start_o
);

    xint_ctrl_t ctrl;
    xint_evt_t  evt;
    logic       pin_s;

    xint_ctrl_reg #(.RST_VAL(CTRL_RST)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctrl_wr_i),
        .wr_data (acc_wr_i),
        .rd_en   (ctrl_rd_i),
        .rd_data (acc_rd_o),
        .ctrl_o  (ctrl)
    );

    xint_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_i),
        .q   (pin_s)
    );

    xint_edge_det u_det (
        .clk     (clk),
        .rst     (rst),
        .pin_s   (pin_s),
        .ctrl    (ctrl),
        .evt_o   (evt),
        .level_o (skip_lvl_o)
    );

    xint_req_flag u_flag (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .clr   (req_clr_i),
        .req_o (req_o),
        .tmr_o (tmr_start_o)
    );

    // R9
    tmr_with_req_chk: assert property (@(posedge clk) disable iff (rst)
        tmr_start_o |-> req_o);

    // R3
    skip_off_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.pin_en |-> !skip_lvl_o);

endmodule

// File: tb/xint_edge_unit_tb.sv
module xint_edge_unit_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin_i = 1'b0;
    logic [3:0] acc_wr_i = 4'h0;
    logic       ctrl_wr_i = 1'b0;
    logic       ctrl_rd_i = 1'b0;
    logic [3:0] acc_rd_o;
    logic       req_clr_i = 1'b0;
    logic       req_o;
    logic       skip_lvl_o;
    logic       tmr_start_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        string tag;
        logic  req;
        logic  tmr;
        logic  skip;
    } exp_t;

    exp_t q[$];
    event ev_chk;

    always #10 clk = ~clk;

    xint_edge_unit u_dut (
        .clk         (clk),
        .rst         (rst),
        .pin_i       (pin_i),
        .acc_wr_i    (acc_wr_i),
        .ctrl_wr_i   (ctrl_wr_i),
        .ctrl_rd_i   (ctrl_rd_i),
        .acc_rd_o    (acc_rd_o),
        .req_clr_i   (req_clr_i),
        .req_o       (req_o),
        .skip_lvl_o  (skip_lvl_o),
        .tmr_start_o (tmr_start_o)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic r, input logic t, input logic s);
        exp_t e;
        e.tag = tag; e.req = r; e.tmr = t; e.skip = s;
        q.push_back(e);
        -> ev_chk;
        #1;
    endtask

    // Monitor: pops expected items and compares against outputs.
    initial begin
        forever begin
            @(ev_chk);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (req_o !== e.req || tmr_start_o !== e.tmr || skip_lvl_o !== e.skip) begin
                    errors++;
                    $display("FAIL %s: req/tmr/skip actual %b%b%b expected %b%b%b",
                             e.tag, req_o, tmr_start_o, skip_lvl_o, e.req, e.tmr, e.skip);
                end
            end
        end
    end

    task automatic check_rd(input string tag, input logic rd, input logic [3:0] exp);
        ctrl_rd_i = rd;
        #1;
        checks++;
        if (acc_rd_o !== exp) begin
            errors++;
            $display("FAIL %s: acc_rd_o actual %b expected %b", tag, acc_rd_o, exp);
        end
        ctrl_rd_i = 1'b0;
        #1;
    endtask

    task automatic write_ctrl(input logic [3:0] v);
        acc_wr_i  = v;
        ctrl_wr_i = 1'b1;
        tick(1);
        ctrl_wr_i = 1'b0;
    endtask

    task automatic clear_req(input string tag);
        req_clr_i = 1'b1;
        tick(1);
        req_clr_i = 1'b0;
        checks++;
        if (req_o !== 1'b0) begin
            errors++;
            $display("FAIL %s: req_o after clear actual %b expected 0", tag, req_o);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        expect_out("R1 reset outputs", 0, 0, 0);
        check_rd("R1 reset control word", 1'b1, 4'b0000);

        // R3: control 0000, pin toggles have no effect
        pin_i = 1'b1; tick(3); expect_out("R3 disabled rise", 0, 0, 0);
        pin_i = 1'b0; tick(3); expect_out("R3 disabled fall", 0, 0, 0);
        pin_i = 1'b1; tick(3); expect_out("R3 disabled rise again", 0, 0, 0);

        // R2: write 1000 (enable, falling, single, no timer), read back
        write_ctrl(4'b1000);
        check_rd("R2 readback", 1'b1, 4'b1000);
        check_rd("R2 no strobe reads zero", 1'b0, 4'b0000);
        acc_wr_i = 4'b1111; tick(1);
        check_rd("R2 bus without strobe ignored", 1'b1, 4'b1000);
        tick(2);
        expect_out("R4 pin high no request", 0, 0, 0);

        // R4: falling edge
        pin_i = 1'b0; tick(2);
        expect_out("R10 low level seen after two edges", 0, 0, 1);
        tick(1);
        expect_out("R4 falling edge sets request, R9 no timer", 1, 0, 1);
        pin_i = 1'b1; tick(3);
        expect_out("R7 request sticky", 1, 0, 0);
        clear_req("R7 clear");
        pin_i = 1'b1; tick(3);
        expect_out("R4 rising ignored", 0, 0, 0);

        // R11 + R5 + R9: write 1101 with pin high gives apparent edge
        write_ctrl(4'b1101);
        expect_out("R11 polarity/enable write edge pending", 0, 0, 1);
        tick(1);
        expect_out("R11 write raises request, R9 timer pulse", 1, 1, 1);
        tick(1);
        expect_out("R9 timer pulse one cycle", 1, 0, 1);
        clear_req("R7 clear after R11");
        pin_i = 1'b0; tick(2);
        expect_out("R10 high-level test false on low pin", 0, 0, 0);
        tick(1);
        expect_out("R5 falling ignored", 0, 0, 0);
        pin_i = 1'b1; tick(2);
        expect_out("R5 level seen, request not yet", 0, 0, 1);
        tick(1);
        expect_out("R5 rising sets request, R9 timer", 1, 1, 1);
        tick(1);
        expect_out("R9 timer pulse ends", 1, 0, 1);
        clear_req("R7 clear after R5");

        // R6: both edges, 1110
        write_ctrl(4'b1110);
        tick(2);
        expect_out("R6 write without level change no request", 0, 0, 1);
        pin_i = 1'b0; tick(3);
        expect_out("R6 falling sets request", 1, 0, 0);
        clear_req("R7 clear after R6 fall");
        pin_i = 1'b1; tick(3);
        expect_out("R6 rising sets request", 1, 0, 1);

        // R8: edge and clear in the same cycle
        pin_i = 1'b0; tick(2);
        req_clr_i = 1'b1; tick(1); req_clr_i = 1'b0;
        expect_out("R8 set wins over clear", 1, 0, 0);
        clear_req("R8 follow-up clear");

        // R11: polarity change in both-edge mode (pin low)
        write_ctrl(4'b1010);
        expect_out("R11 polarity flip pending", 0, 0, 1);
        tick(1);
        expect_out("R11 polarity flip raises request", 1, 0, 1);
        clear_req("R11 clear after polarity");
        // R11: disabling while active level present
        write_ctrl(4'b0010);
        expect_out("R11 disable pending, R3 skip low", 0, 0, 0);
        tick(1);
        expect_out("R11 disable raises request", 1, 0, 0);
        clear_req("R11 clear after disable");

        // R3: stays quiet while disabled
        pin_i = 1'b1; tick(3);
        expect_out("R3 disabled both-mode rise", 0, 0, 0);
        pin_i = 1'b0; tick(3);
        expect_out("R3 disabled both-mode fall, skip low", 0, 0, 0);
        check_rd("R2 final readback", 1'b1, 4'b0010);

        tick(2);
        finish_run();
    end

endmodule